// File: doc/BRIEF.md
# Serial Memory Slave Front End with Pause

This block is the bit-level front end of a serial memory slave. It watches the four serial pins (serial clock, chip select, data in, pause request), turns the data-in stream into bytes for the command logic behind it, and shifts response bytes out on a data-out pin that has its own enable, so a pad can leave it floating. It accepts a master that idles the serial clock low and one that idles it high. SI is taken on rising serial clock edges and data out changes only after falling edges. Both directions are most significant bit first.

All serial pins are sampled on the system clock `clk`, and edges of the serial clock are found by comparing consecutive samples. A pause request freezes a transfer in mid-byte without ending the sequence. Entry to and exit from the pause both wait for the serial clock to be low. The bit position and the partial byte are kept through the pause. Raising chip select always clears the sequence, including the pause.

Received bytes come out as `rx_valid`/`rx_data` with no ready: the serial master cannot be stalled, so the consumer must take the byte in the one cycle it is valid. Response bytes use a valid/ready pair. `tx_ready` pulses once per completed byte. If `tx_valid` is high in that cycle, `tx_data` is driven during the next byte. If it is low, data out stays disabled for that byte and the block does not wait. Back-pressure is not possible in either direction.

Top module: `spi_hold_frontend`

## Requirements
- R1: After reset, and whenever chip select is high, `rx_valid`, `tx_ready`, `seq_start` and `so_oe` are low.
- R2: With chip select low and no pause, `spi_si` is captured at each clock edge that first samples `spi_sck` high, most significant bit first. After the eighth such capture, `rx_valid` is high for exactly one cycle, starting at that edge, with the assembled byte on `rx_data`.
- R3: Transfers whose serial clock idles low and transfers whose serial clock idles high give the same received and returned bytes. A falling edge that comes before the first rising edge of a sequence shifts nothing in.
- R4: `seq_start` is high for exactly one cycle after the clock edge that first samples `spi_cs_n` low following a high sample.
- R5: `tx_ready` is high in the same cycles as `rx_valid`. If `tx_valid` is high then, `tx_data` appears on `spi_so` during the next byte, most significant bit first. Its first bit comes after the first falling serial clock edge that follows the byte boundary, and each later bit after each later falling edge. `spi_so` changes only after a falling edge.
- R6: `so_oe` is low during the first byte of a sequence, during any byte whose offered response had `tx_valid` low, during a pause, and while chip select is high. Otherwise it is high from the first falling edge of a byte with a response.
- R7: A high chip select discards a partial byte, the bit position and any pause, so the next sequence starts from bit 7 of a new byte.
- R8: A pause starts at the first clock edge that samples `spi_hold_n` low together with `spi_sck` low. If `spi_hold_n` falls while `spi_sck` is high, the falling serial clock edge that follows is still acted on, and the pause starts with it.
- R9: A pause ends at the first clock edge that samples `spi_hold_n` high together with `spi_sck` low. A serial clock edge seen while paused is never acted on, including the falling edge that ends a pause.
- R10: While paused, serial clock edges and `spi_si` have no effect. After the pause, shifting resumes at the same bit position with the partial byte intact.
- R11: `spi_hold_n` has no effect while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | input | 1 | Serial clock from the master, either idle level |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| so_oe | output | 1 | Drive enable for `spi_so`; low means the pad floats |
| rx_valid | output | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | output | W | Last received byte |
| seq_start | output | 1 | One-cycle pulse at the start of a sequence |
| tx_ready | output | 1 | Block takes a response byte in this cycle |
| tx_valid | input | 1 | A response byte is offered |
| tx_data | input | W | Response byte |

## Verification
The assertions assume that the serial pins are synchronous to `clk` and that each serial clock phase lasts at least two clock cycles. They also assume that chip select and pause changes fall in a different cycle from any serial clock edge, and that `tx_data`/`tx_valid` are settled in the cycle `tx_ready` is high. Under those conditions a received-byte strobe can never last two cycles, and a change of pause state is always tied to a low serial clock. The bench master holds every serial clock phase for three clock cycles. It changes chip select and the pause request only between serial clock edges, and it sets the response byte at the start of each byte.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  // pause state of the front end
  typedef enum logic {
    HS_RUN    = 1'b0,
    HS_PAUSED = 1'b1
  } hold_st_t;

  localparam int unsigned FE_BYTE_W = 8;
endpackage

// File: rtl/spi_fe_gate.sv
module spi_fe_gate
  import spi_fe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_hold_n,
  output logic live,
  output logic held,
  output logic rise,
  output logic fall,
  output logic seq_start
);
  logic     sck_q;
  logic     cs_n_q;
  hold_st_t hst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      cs_n_q    <= 1'b1;
      hst_q     <= HS_RUN;
      seq_start <= 1'b0;
    end else begin
      sck_q     <= spi_sck;
      cs_n_q    <= spi_cs_n;
      seq_start <= cs_n_q & ~spi_cs_n;
      if (spi_cs_n) begin
        hst_q <= HS_RUN;
      end else if (!spi_sck) begin
        // pause state follows the request only in the low clock phase
        hst_q <= spi_hold_n ? HS_RUN : HS_PAUSED;
      end
    end
  end

  always_comb begin
    live = ~spi_cs_n;
    held = (hst_q == HS_PAUSED);
    rise = live & ~held & spi_sck & ~sck_q;
    fall = live & ~held & ~spi_sck & sck_q;
  end

  // R8 / R9: pause state only changes on a sample with serial clock low
  a_r8_pause_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!spi_cs_n) && (held != $past(held))) |-> !$past(spi_sck));

  // R7: a high chip select clears the pause
  a_r7_cs_clears_pause: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> !held);
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live,
  input  logic         rise,
  input  logic         spi_si,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         at_bound
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  next_sh;
  logic          done;

  always_comb begin
    next_sh  = {sh[W-2:0], spi_si};
    done     = rise && (cnt == LAST);
    at_bound = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (!live) begin
      cnt      <= '0;
      sh       <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= done;
      if (rise) begin
        sh  <= next_sh;
        cnt <= done ? '0 : cnt + 1'b1;
      end
      if (done) rx_data <= next_sh;
    end
  end

  // R2: a received-byte strobe lasts one cycle
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: without an accepted rising edge the bit position is kept
  a_r10_position_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !rise) |=> $stable(cnt));
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live,
  input  logic         held,
  input  logic         fall,
  input  logic         at_bound,
  input  logic         take,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         spi_so,
  output logic         so_oe
);
  logic [W-1:0] sh;
  logic         has;
  logic         so_q;
  logic         en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      has  <= 1'b0;
      so_q <= 1'b0;
      en_q <= 1'b0;
    end else if (!live) begin
      sh   <= '0;
      has  <= 1'b0;
      so_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      if (take) begin
        has <= tx_valid;
        sh  <= tx_data;
      end
      if (fall) begin
        so_q <= sh[W-1];
        sh   <= {sh[W-2:0], 1'b0};
        if (at_bound) en_q <= has;
      end
    end
  end

  assign spi_so = so_q;
  assign so_oe  = en_q & live & ~held;

  // R6: drive enable only switches on at a byte-boundary falling edge
  a_r6_enable_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> ($past(fall) && $past(at_bound)));

  // R5: output bit only moves after a falling edge
  a_r5_so_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !fall) |=> $stable(so_q));
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
  parameter int unsigned W = spi_fe_pkg::FE_BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spi_sck,
  input  logic         spi_cs_n,
  input  logic         spi_hold_n,
  input  logic         spi_si,
  output logic         spi_so,
  output logic         so_oe,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         seq_start,
  output logic         tx_ready,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data
);
  logic live, held, rise, fall, at_bound;

  spi_fe_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_hold_n (spi_hold_n),
    .live       (live),
    .held       (held),
    .rise       (rise),
    .fall       (fall),
    .seq_start  (seq_start)
  );

  spi_fe_rx #(.W(W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live),
    .rise     (rise),
    .spi_si   (spi_si),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .at_bound (at_bound)
  );

  assign tx_ready = rx_valid;

  spi_fe_tx #(.W(W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live),
    .held     (held),
    .fall     (fall),
    .at_bound (at_bound),
    .take     (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .spi_so   (spi_so),
    .so_oe    (so_oe)
  );
endmodule

// File: tb/sim_spi_hold_frontend.sv
module sim_spi_hold_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_hold_n = 1'b1, spi_si = 1'b0;
  logic spi_so, so_oe, rx_valid, seq_start, tx_ready;
  logic [7:0] rx_data;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_hold_frontend u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_hold_n(spi_hold_n), .spi_si(spi_si), .spi_so(spi_so), .so_oe(so_oe),
    .rx_valid(rx_valid), .rx_data(rx_data), .seq_start(seq_start),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every clock
  int         m_bit;
  logic [7:0] m_acc, m_sh, m_rxd;
  bit m_held, m_has, m_en, m_so, m_rxv, m_start, m_ps, m_pc;

  always @(posedge clk) begin
    bit r, f, take;
    if (!rst_n) begin
      m_bit = 0; m_acc = 0; m_sh = 0; m_rxd = 0; m_held = 0; m_has = 0;
      m_en = 0; m_so = 0; m_rxv = 0; m_start = 0; m_ps = 0; m_pc = 1;
    end else begin
      r = !spi_cs_n && !m_held && spi_sck && !m_ps;
      f = !spi_cs_n && !m_held && !spi_sck && m_ps;
      take = m_rxv;
      m_start = m_pc && !spi_cs_n;
      if (spi_cs_n) begin
        m_bit = 0; m_acc = 0; m_sh = 0; m_held = 0; m_has = 0;
        m_en = 0; m_so = 0; m_rxv = 0;
      end else begin
        m_rxv = r && (m_bit == 7);
        if (f) begin
          if (m_bit == 0) m_en = m_has;
          m_so = m_sh[7];
          m_sh = {m_sh[6:0], 1'b0};
        end
        if (r) begin
          if (m_bit == 7) m_rxd = {m_acc[6:0], spi_si};
          m_acc = {m_acc[6:0], spi_si};
          m_bit = (m_bit + 1) % 8;
        end
        if (take) begin m_has = tx_valid; m_sh = tx_data; end
        if (!spi_sck) m_held = !spi_hold_n;
      end
      m_ps = spi_sck;
      m_pc = spi_cs_n;
    end
  end

  logic [7:0] got_q[$];
  int nstart = 0;

  always @(negedge clk) begin
    bit exp_oe;
    if (rst_n && !finished) begin
      chk(rx_valid == m_rxv, "R2", "rx_valid", rx_valid, m_rxv);
      if (m_rxv) chk(rx_data == m_rxd, "R2", "rx_data", rx_data, m_rxd);
      chk(seq_start == m_start, "R4", "seq_start", seq_start, m_start);
      chk(tx_ready == m_rxv, "R5", "tx_ready", tx_ready, m_rxv);
      exp_oe = m_en && !spi_cs_n && !m_held;
      chk(so_oe == exp_oe, "R6", "so_oe", so_oe, exp_oe);
      if (exp_oe) chk(spi_so == m_so, "R5", "spi_so", spi_so, m_so);
      if (rx_valid) got_q.push_back(rx_data);
      if (seq_start) nstart++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  logic [7:0] mo [8];
  bit         rvld [8];
  logic [7:0] rdat [8];
  logic [7:0] mi [8];
  bit         mi_oe [8];

  // hk: 0 none, 1 pause requested with clock high, 2 requested with clock low
  task automatic xfer(input bit mode3, input int n, input int hbyte,
                      input int hbit, input int hk);
    got_q.delete();
    nstart = 0;
    spi_sck = mode3; tick(2);
    spi_cs_n = 0; tick(H);
    for (int i = 0; i < n; i++) begin
      tx_valid = rvld[i]; tx_data = rdat[i];
      mi_oe[i] = 1;
      for (int b = 7; b >= 0; b--) begin
        if (hk == 1 && i == hbyte && b == hbit) begin spi_hold_n = 0; tick(H); end
        spi_sck = 0; tick(H);
        if (hk != 0 && i == hbyte && b == hbit) begin
          if (hk == 2) begin spi_hold_n = 0; tick(H); end
          repeat (3) begin
            spi_sck = 1; spi_si = ~spi_si; tick(H);
            spi_sck = 0; tick(H);
          end
          if (hk == 2) begin
            spi_sck = 1; tick(H);
            spi_hold_n = 1; tick(H);
            spi_sck = 0; tick(H);
          end else begin
            spi_hold_n = 1; tick(H);
          end
        end
        spi_si = mo[i][b]; tick(H);
        mi[i][b] = spi_so;
        mi_oe[i] = mi_oe[i] & so_oe;
        spi_sck = 1; tick(H);
      end
    end
    if (!mode3) begin spi_sck = 0; tick(H); end
    spi_cs_n = 1; tick(H);
  endtask

  task automatic judge(input int n, input string tag);
    chk(got_q.size() == n, tag, "received byte count", got_q.size(), n);
    for (int i = 0; i < n && i < got_q.size(); i++)
      chk(got_q[i] == mo[i], tag, "received byte", got_q[i], mo[i]);
    chk(nstart == 1, "R4", "sequence start pulses", nstart, 1);
    chk(mi_oe[0] == 0, "R6", "enable in first byte", mi_oe[0], 0);
    for (int i = 1; i < n; i++) begin
      chk(mi_oe[i] == rvld[i-1], "R6", "enable per byte", mi_oe[i], rvld[i-1]);
      if (rvld[i-1]) chk(mi[i] == rdat[i-1], "R5", "returned byte", mi[i], rdat[i-1]);
    end
  endtask

  task automatic load(input logic [7:0] seed, input bit skip1);
    for (int i = 0; i < 8; i++) begin
      mo[i]   = seed ^ 8'(i * 37);
      rdat[i] = ~seed + 8'(i * 29);
      rvld[i] = !(skip1 && i == 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1;
    tick(2);
    // R1: idle outputs after reset
    chk(rx_valid == 0, "R1", "rx_valid idle", rx_valid, 0);
    chk(tx_ready == 0, "R1", "tx_ready idle", tx_ready, 0);
    chk(seq_start == 0, "R1", "seq_start idle", seq_start, 0);
    chk(so_oe == 0, "R1", "so_oe idle", so_oe, 0);

    load(8'hA5, 0); xfer(0, 4, 0, 0, 0); judge(4, "R2");
    load(8'h3C, 0); xfer(1, 4, 0, 0, 0); judge(4, "R3");
    load(8'h81, 1); xfer(0, 3, 0, 0, 0); judge(3, "R6");
    load(8'h5E, 0); xfer(0, 3, 1, 4, 1); judge(3, "R8");
    load(8'hC3, 0); xfer(1, 3, 2, 2, 2); judge(3, "R9");
    load(8'h17, 0); xfer(1, 3, 1, 0, 1); judge(3, "R10");

    // R11: pause request toggled while deselected has no effect
    spi_hold_n = 0;
    repeat (4) begin spi_sck = ~spi_sck; tick(H); end
    chk(so_oe == 0, "R11", "so_oe while deselected", so_oe, 0);
    spi_hold_n = 1; tick(H);
    load(8'h6B, 0); xfer(0, 2, 0, 0, 0); judge(2, "R11");

    // R7: abandon a sequence mid-byte while paused
    spi_sck = 0; tick(2);
    spi_cs_n = 0; tick(H);
    for (int b = 0; b < 5; b++) begin
      spi_sck = 0; spi_si = b[0]; tick(H);
      spi_sck = 1; tick(H);
    end
    spi_sck = 0; tick(H);
    spi_hold_n = 0; tick(H);
    spi_cs_n = 1; tick(H);
    chk(so_oe == 0, "R1", "so_oe after deselect", so_oe, 0);
    spi_hold_n = 1; tick(H);
    load(8'hE2, 0); xfer(0, 3, 0, 0, 0); judge(3, "R7");

    tick(4);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule